// File: doc/BRIEF.md
# Push-Button Hold Duration Classifier

This block watches a front-panel push-button that has already been debounced and brought into the clock domain. It decides what each press means. A free-running tick counter stamps the press edge. The elapsed time of the hold is then measured in ticks, and each hold is sorted into one of three classes: too short, a normal press, or a long-hold failsafe. A normal press ends with a one-cycle toggle request, which a power controller can use to switch its supply state on or off.

A hold that reaches the long-hold limit raises the failsafe flag at once, while the button is still down. The release that follows this hold only clears the flag and produces no toggle. A saturating counter records how many failsafe events have happened, and an external strobe clears it. With the default parameters a tick runs at 8192 Hz. A valid press must exceed 1638 ticks (about 200 ms), and the long-hold limit is 49152 ticks (6 s).

Top module: `btn_hold_classifier`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, toggle_req, failsafe and fs_count are all zero. A reset during a failsafe hold clears the flag.
- R2: The timestamp counter advances only in cycles where tick_en is high. The hold time is the number of counted ticks between the clock edge that sees the button rise and the clock edge that sees it fall.
- R3: A release whose hold time is strictly greater than MIN_TICKS makes toggle_req high for exactly one cycle, in the cycle right after the edge that sees the release.
- R4: A release whose hold time is MIN_TICKS or less is ignored. No toggle is produced, failsafe stays low and fs_count is unchanged.
- R5: While the button is still held, failsafe rises in the cycle after the edge at which the hold reaches LONG_TICKS ticks. It is low before that.
- R6: When failsafe is set, the next release clears it and produces no toggle_req.
- R7: A release seen on the same edge at which the hold equals LONG_TICKS counts as a normal press. It produces a toggle, and failsafe is not raised.
- R8: Each entry into failsafe adds one to fs_count. The count holds at 2^CNT_W-1 and does not wrap.
- R9: A cnt_clr pulse zeroes fs_count. If a clear and a failsafe entry happen on the same edge, the clear wins.
- R10: Hold times are computed modulo 2^TS_W, so a timestamp wrap between press and release does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| tick_en | input | 1 | Tick strobe that advances the timestamp counter |
| btn_level | input | 1 | Synchronized, debounced button level (1 = pressed) |
| cnt_clr | input | 1 | Strobe that clears the failsafe event count |
| toggle_req | output | 1 | One-cycle request produced by a valid press |
| failsafe | output | 1 | High from the long-hold limit until the button is released |
| fs_count | output | CNT_W | Saturating count of failsafe events |

## Verification
The bench runs with short limits so that every class of hold fits in a short run. It tries hold lengths just below, at and just above the minimum. Together these separate a strictly-greater test from a greater-or-equal test. It also tries holds at, one past and well past the long limit, which separate the release-wins case from a failsafe entry and show that the release which follows is swallowed. Holds with tick_en partly low show that time is counted in ticks and not in cycles. A long run of valid presses pushes the 8-bit stamp through several wraps. Repeated failsafe holds, together with clear strobes alone and at the same edge as a failsafe entry, check the saturation and the clear priority.

// File: rtl/btn_hold_pkg.sv
package btn_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HELD = 2'd1,
    ST_FS   = 2'd2
  } hold_st_e;
endpackage

// File: rtl/btn_tick_stamp.sv
module btn_tick_stamp #(
  parameter int unsigned TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  output logic [TS_W-1:0] now
);
  logic [TS_W-1:0] now_d;

  always_comb begin
    now_d = now + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= '0;
    end else if (tick_en) begin
      now <= now_d;
    end
  end
endmodule

// File: rtl/btn_edge_det.sv
module btn_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level;
    end
  end

  always_comb begin
    rise = level & ~level_q;
    fall = ~level & level_q;
  end
endmodule

// File: rtl/btn_hold_fsm.sv
module btn_hold_fsm
  import btn_hold_pkg::*;
#(
  parameter int unsigned TS_W       = 16,
  parameter int unsigned MIN_TICKS  = 1638,
  parameter int unsigned LONG_TICKS = 49152
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic            rise,
  input  logic            fall,
  output logic            toggle_q,
  output logic            fs_enter,
  output logic            fs_flag
);
  localparam logic [TS_W-1:0] MIN_T  = TS_W'(MIN_TICKS);
  localparam logic [TS_W-1:0] LONG_T = TS_W'(LONG_TICKS);

  hold_st_e        st_q, st_d;
  logic [TS_W-1:0] stamp_q;
  logic            stamp_en;
  logic [TS_W-1:0] elapsed;
  logic            toggle_d;

  // modulo difference: correct across a counter wrap
  always_comb begin
    elapsed = now - stamp_q;
  end

  always_comb begin
    st_d     = st_q;
    stamp_en = 1'b0;
    toggle_d = 1'b0;
    fs_enter = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rise) begin
          st_d     = ST_HELD;
          stamp_en = 1'b1;
        end
      end
      ST_HELD: begin
        if (fall) begin
          st_d     = ST_IDLE;
          toggle_d = (elapsed > MIN_T);
        end else if (elapsed >= LONG_T) begin
          st_d     = ST_FS;
          fs_enter = 1'b1;
        end
      end
      ST_FS: begin
        if (fall) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      toggle_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      toggle_q <= toggle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
    end else if (stamp_en) begin
      stamp_q <= now;
    end
  end

  always_comb begin
    fs_flag = (st_q == ST_FS);
  end
endmodule

// File: rtl/btn_fs_counter.sv
module btn_fs_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    count_en = clr | (inc && (count != CNT_MAX));
    count_d  = clr ? '0 : count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_en) begin
      count <= count_d;
    end
  end
endmodule

// File: rtl/btn_hold_classifier.sv
module btn_hold_classifier #(
  parameter int unsigned TS_W       = 16,
  parameter int unsigned MIN_TICKS  = 1638,
  parameter int unsigned LONG_TICKS = 49152,
  parameter int unsigned CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             btn_level,
  input  logic             cnt_clr,
  output logic             toggle_req,
  output logic             failsafe,
  output logic [CNT_W-1:0] fs_count
);
  logic [TS_W-1:0] now;
  logic            rise;
  logic            fall;
  logic            fs_enter;

  btn_tick_stamp #(.TS_W(TS_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .now     (now)
  );

  btn_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (btn_level),
    .rise  (rise),
    .fall  (fall)
  );

  btn_hold_fsm #(
    .TS_W       (TS_W),
    .MIN_TICKS  (MIN_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .now      (now),
    .rise     (rise),
    .fall     (fall),
    .toggle_q (toggle_req),
    .fs_enter (fs_enter),
    .fs_flag  (failsafe)
  );

  btn_fs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fs_enter),
    .clr   (cnt_clr),
    .count (fs_count)
  );
endmodule

// File: rtl/btn_hold_classifier_chk.sv
module btn_hold_classifier_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             btn_level,
  input logic             cnt_clr,
  input logic             toggle_req,
  input logic             failsafe,
  input logic [CNT_W-1:0] fs_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R3: the toggle request lasts one cycle
  p_toggle_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_req |=> !toggle_req);

  // R6: no toggle while the failsafe flag is up
  p_no_toggle_in_fs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    failsafe |-> !toggle_req);

  // R6: the flag drops only on a release
  p_fs_drop_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(failsafe) |-> !$past(btn_level));

  // R8: failsafe entry adds one unless saturated or cleared
  p_fs_increment_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(failsafe) && !$past(cnt_clr) && ($past(fs_count) != CMAX))
      |-> (fs_count == $past(fs_count) + CNT_W'(1)));

  // R8: the count moves only on failsafe entry or clear
  p_count_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_count != $past(fs_count)) |-> ($rose(failsafe) || $past(cnt_clr)));

  // R9: clear strobe empties the count
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (fs_count == '0));
endmodule

bind btn_hold_classifier btn_hold_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .btn_level  (btn_level),
  .cnt_clr    (cnt_clr),
  .toggle_req (toggle_req),
  .failsafe   (failsafe),
  .fs_count   (fs_count)
);

// File: tb/btn_hold_classifier_tb.sv
module btn_hold_classifier_tb;
  localparam int unsigned TS_W  = 8;
  localparam int unsigned MINT  = 10;
  localparam int unsigned LONGT = 60;
  localparam int unsigned CW    = 2;
  localparam int unsigned CMAX  = (1 << CW) - 1;

  localparam int NVEC = 7;
  localparam int VHOLD [NVEC] = '{5, 10, 11, 30, 60, 61, 100};
  localparam int VTOG  [NVEC] = '{0,  0,  1,  1,  1,  0,   0};
  localparam int VFS   [NVEC] = '{0,  0,  0,  0,  0,  1,   1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick_en;
  logic          btn_level;
  logic          cnt_clr;
  logic          toggle_req;
  logic          failsafe;
  logic [CW-1:0] fs_count;

  int checks = 0;
  int errors = 0;
  int tog_cnt = 0;
  int exp_cnt = 0;
  logic tog_prev = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  btn_hold_classifier #(
    .TS_W(TS_W), .MIN_TICKS(MINT), .LONG_TICKS(LONGT), .CNT_W(CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .btn_level(btn_level),
    .cnt_clr(cnt_clr), .toggle_req(toggle_req), .failsafe(failsafe),
    .fs_count(fs_count)
  );

  always @(negedge clk) begin
    if (toggle_req) tog_cnt++;
    if (toggle_req && tog_prev) begin
      errors++;
      $display("FAIL R3 toggle wide: actual=2 expected=1 cycles");
    end
    tog_prev = toggle_req;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold the button for n cycles; tick_en goes high at cycle ten_at (0 = always on)
  task automatic hold(input int n, input int etog, input int efs,
                      input int ten_at, input bit clr_at_limit, input string tag);
    int t0;
    t0 = tog_cnt;
    @(negedge clk);
    btn_level = 1'b1;
    if (ten_at > 0) tick_en = 1'b0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (j == ten_at) tick_en = 1'b1;
      if (clr_at_limit && j == LONGT) cnt_clr = 1'b1;
      if (clr_at_limit && j == LONGT + 1) cnt_clr = 1'b0;
      if (n > LONGT && j == LONGT)     chk({tag, " R5 fs early"}, failsafe, 0);
      if (n > LONGT && j == LONGT + 1) chk({tag, " R5 fs set"}, failsafe, 1);
    end
    btn_level = 1'b0;
    cnt_clr   = 1'b0;
    @(negedge clk);
    chk({tag, " R3 toggle timing"}, toggle_req, etog);
    repeat (2) @(negedge clk);
    tick_en = 1'b1;
    chk({tag, " R6 fs cleared"}, failsafe, 0);
    chk({tag, " R4 toggle count"}, tog_cnt - t0, etog);
    if (efs != 0 && !clr_at_limit && exp_cnt < int'(CMAX)) exp_cnt++;
    if (clr_at_limit) exp_cnt = 0;
    chk({tag, " R8 count"}, int'(fs_count), exp_cnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; btn_level = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset toggle", toggle_req, 0);
    chk("R1 reset failsafe", failsafe, 0);
    chk("R1 reset count", int'(fs_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'({toggle_req, failsafe, fs_count}), 0);

    // vector table: R3, R4, R5, R6, R7, R8
    for (int v = 0; v < NVEC; v++) begin
      hold(VHOLD[v], VTOG[v], VFS[v], 0, 1'b0, $sformatf("vec%0d", v));
    end

    // R10: many valid presses run the 8-bit stamp through several wraps
    for (int k = 0; k < 25; k++) begin
      hold(12, 1, 0, 0, 1'b0, "R10 wrap");
    end

    // R2: only ticks count; 5 ticks is too short, 12 ticks is valid
    hold(20, 0, 0, 15, 1'b0, "R2 gated short");
    hold(20, 1, 0, 8,  1'b0, "R2 gated long");

    // R8: saturation at CMAX
    hold(61, 0, 1, 0, 1'b0, "R8 third");
    hold(70, 0, 1, 0, 1'b0, "R8 saturate");
    chk("R8 saturated value", int'(fs_count), int'(CMAX));

    // R9: clear alone, then clear on the same edge as a failsafe entry
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    chk("R9 clear", int'(fs_count), 0);
    exp_cnt = 0;
    hold(61, 0, 1, 0, 1'b1, "R9 clear wins");
    hold(61, 0, 1, 0, 1'b0, "R9 after clear");

    // R1: reset in the middle of a failsafe hold
    @(negedge clk);
    btn_level = 1'b1;
    repeat (65) @(negedge clk);
    chk("R1 fs before reset", failsafe, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears fs", failsafe, 0);
    chk("R1 reset clears count", int'(fs_count), 0);
    btn_level = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", int'({toggle_req, failsafe}), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule